// File: doc/BRIEF.md
# SMBus Two-Configuration Pin Driver

This block is a bus slave that turns single-byte SMBus writes into the states of three open-drain style pins, and turns single-byte reads into a snapshot of those pins. Each write carries a selector in its top bit. The selector steers the remaining seven bits into one of two stored configurations: a normal one and a suspend one. Each configuration holds three pin enables and four interrupt masks.

A separate suspend input picks which stored configuration drives the pins and the mask outputs. That path is purely combinational, so a power-plane change needs no bus traffic at all. A read returns the live pin levels and a thermal fault flag that logic outside the block supplies. The slave address is fixed at reset from a three-level select code. SCL and SDA are oversampled by the system clock through a synchronizer.

Top module: `smb_pin_expander`

## Requirements
- R1: The 7-bit address is loaded only while reset is held. The select code addr_sel_i 00 (tied low) gives 0x20+ADDR_VARIANT, 01 (floating) gives 0x3C+ADDR_VARIANT, and 10 or 11 (tied high) gives 0x48+ADDR_VARIANT. Changing addr_sel_i after reset does not change the address.
- R2: After its own address and a write bit (0), the slave pulls SDA low for the address acknowledge. It pulls SDA low again for the acknowledge that follows the eighth data bit.
- R3: The data byte takes effect at the SCL rising edge of the second acknowledge clock. If bit 7 is 1, bits 6..0 go to the normal configuration; if bit 7 is 0, they go to the suspend configuration. The other configuration is left unchanged.
- R4: A START or STOP seen before all eight data bits are clocked in discards the transfer, and neither configuration changes.
- R5: In the selected configuration, bits 2..0 drive pins 3..1, and a 0 turns the pin on (pin_pd_o bit = 1). Bits 6..3 appear on mask_o[3:0], with mask_o[3] the START-STOP mask and mask_o[2:0] the pin 3..1 masks.
- R6: After reset, both configurations hold all four masks at 1. The pin bits hold 1 (released) when OUT_RST_RELEASED=1, and 0 (driven) otherwise.
- R7: suspend_n_i low routes the suspend configuration to pin_pd_o and mask_o, and high routes the normal one. The change happens in the same cycle, with no clock edge involved.
- R8: A read to the own address (R/W bit 1) is acknowledged. The returned byte is {4'b0000, therm_flag_i, pin_i[2], pin_i[1], pin_i[0]}, MSB first. The inputs are sampled at the SCL falling edge that ends the address acknowledge.
- R9: A non-matching address gets no acknowledge, and the slave stays off SDA until the next START.
- R10: A read ends when the master does not acknowledge the data byte. SDA is then released.
- R11: The slave starts pulling SDA low only after it has seen an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; the address is captured while it is low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pd_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Three-level address select code |
| suspend_n_i | input | 1 | Low selects the suspend configuration |
| pin_i | input | 3 | Live levels of pins 3..1 |
| therm_flag_i | input | 1 | Latched thermal fault flag |
| pin_pd_o | output | 3 | 1 turns pin on (pulls low) |
| mask_o | output | 4 | Interrupt masks of the routed configuration |

## Verification
The suspend routing is combinational, so the bench checks pin_pd_o and mask_o a couple of nanoseconds after it moves suspend_n_i, without waiting for a clock. Bus results lag the lines by two synchronizer flops plus one edge-detect register plus the output register, about four clocks. Every SCL phase in the bench lasts ten clocks, and SDA is sampled in the middle of the high phase. Configuration effects are checked after the STOP, well after the commit edge. For reads, the bench changes the pins after the sampling fall, which shows that the byte reflects the sample point.

// File: rtl/smbx_pkg.sv
package smbx_pkg;
    localparam int NPIN = 3;
    localparam int CFGW = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } link_st_e;

    typedef struct packed {
        link_st_e    st;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic        rw;
        logic        pd;
        logic        scl_p;
        logic        sda_p;
    } link_t;

    typedef struct packed {
        logic [CFGW-1:0] norm;
        logic [CFGW-1:0] susp;
    } cfg_t;

    function automatic logic [6:0] addr_code(input int variant, input logic [1:0] sel);
        logic [6:0] base;
        case (sel)
            2'b00:   base = 7'h20;
            2'b01:   base = 7'h3C;
            default: base = 7'h48;
        endcase
        return base + 7'(variant);
    endfunction
endpackage

// File: rtl/smbx_sync.sv
module smbx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/smbx_link.sv
module smbx_link
    import smbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic [6:0]      my_addr,
    input  logic [NPIN-1:0] pin_i,
    input  logic            therm_i,
    output logic            sda_pd_o,
    output logic            wr_en_o,
    output logic [7:0]      wr_byte_o
);
    link_t q, d;
    logic  scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] tx;

    always_comb begin
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_c  = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_c   = scl_s & q.scl_p & ~q.sda_p & sda_s;
        tx       = {4'b0000, therm_i, pin_i};
        d        = q;
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
        wr_en_o  = 1'b0;
        unique case (q.st)
            ST_IDLE: ;
            ST_ADDR: begin
                if (scl_rise && q.cnt != 4'd8) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall && q.cnt == 4'd8) begin
                    if (q.sh[7:1] == my_addr) begin
                        d.pd = 1'b1;
                        d.rw = q.sh[0];
                        d.st = ST_AACK;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_AACK: begin
                if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.sh = tx;
                        d.pd = ~tx[7];
                        d.st = ST_RDATA;
                    end else begin
                        d.pd = 1'b0;
                        d.st = ST_WDATA;
                    end
                end
            end
            ST_WDATA: begin
                if (scl_rise && q.cnt != 4'd8) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall && q.cnt == 4'd8) begin
                    d.pd = 1'b1;
                    d.st = ST_WACK;
                end
            end
            ST_WACK: begin
                if (scl_rise) wr_en_o = 1'b1;
                if (scl_fall) begin
                    d.pd = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            ST_RDATA: begin
                if (scl_rise) begin
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall) begin
                    if (q.cnt == 4'd8) begin
                        d.pd = 1'b0;
                        d.st = ST_RACK;
                    end else begin
                        d.sh = {q.sh[6:0], 1'b0};
                        d.pd = ~q.sh[6];
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) d.st = sda_s ? ST_IDLE : ST_AACK;
            end
            default: d.st = ST_IDLE;
        endcase
        if (start_c) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.pd  = 1'b0;
        end else if (stop_c) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.pd  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_pd_o  = q.pd;
    assign wr_byte_o = q.sh;

    // R11: SDA pull-down only begins after SCL was seen low
    assert_pd_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pd) |-> !$past(scl_s));
    // R3: one commit per transfer
    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    // R4: a START or STOP never leads straight into a commit
    assert_abort_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c || stop_c) |=> !wr_en_o);
endmodule

// File: rtl/smbx_cfg.sv
module smbx_cfg
    import smbx_pkg::*;
#(
    parameter bit OUT_RST_RELEASED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [7:0]      wr_byte_i,
    input  logic            suspend_n_i,
    output logic [NPIN-1:0] pin_pd_o,
    output logic [3:0]      mask_o
);
    localparam logic [CFGW-1:0] RST_CFG = {4'b1111, {NPIN{OUT_RST_RELEASED}}};

    cfg_t q, d;
    logic [CFGW-1:0] sel;

    always_comb begin
        d = q;
        if (wr_en_i) begin
            if (wr_byte_i[7]) d.norm = wr_byte_i[CFGW-1:0];
            else              d.susp = wr_byte_i[CFGW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.norm <= RST_CFG;
            q.susp <= RST_CFG;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sel      = suspend_n_i ? q.norm : q.susp;
        pin_pd_o = ~sel[NPIN-1:0];
        mask_o   = sel[CFGW-1:NPIN];
    end

    // R3: a write to one configuration leaves the other one alone
    assert_norm_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_byte_i[7]) |=> $stable(q.norm));
    assert_susp_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_byte_i[7]) |=> $stable(q.susp));
    // R4: without a commit nothing is stored
    assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(q.norm) && $stable(q.susp)));
endmodule

// File: rtl/smb_pin_expander.sv
module smb_pin_expander
    import smbx_pkg::*;
#(
    parameter int ADDR_VARIANT     = 0,
    parameter bit OUT_RST_RELEASED = 1'b1,
    parameter int SYNC_STAGES      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pd_o,
    input  logic [1:0] addr_sel_i,
    input  logic       suspend_n_i,
    input  logic [2:0] pin_i,
    input  logic       therm_flag_i,
    output logic [2:0] pin_pd_o,
    output logic [3:0] mask_o
);
    logic [1:0] bus_s;
    logic [6:0] addr_q, addr_d;
    logic       wr_en;
    logic [7:0] wr_byte;

    always_comb addr_d = rst_n ? addr_q : addr_code(ADDR_VARIANT, addr_sel_i);

    always_ff @(posedge clk) addr_q <= addr_d;

    smbx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (bus_s)
    );

    smbx_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .my_addr   (addr_q),
        .pin_i     (pin_i),
        .therm_i   (therm_flag_i),
        .sda_pd_o  (sda_pd_o),
        .wr_en_o   (wr_en),
        .wr_byte_o (wr_byte)
    );

    smbx_cfg #(.OUT_RST_RELEASED(OUT_RST_RELEASED)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_byte_i   (wr_byte),
        .suspend_n_i (suspend_n_i),
        .pin_pd_o    (pin_pd_o),
        .mask_o      (mask_o)
    );

    // R1: the address never moves once reset is released
    assert_addr_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(addr_q));
endmodule

// File: tb/smb_pin_expander_bench.sv
module smb_pin_expander_bench;
    localparam int H = 10;
    localparam logic [6:0] OWN = 7'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pd;
    logic [1:0] addr_sel = 2'b01;
    logic suspend_n = 1'b1;
    logic [2:0] pins = 3'b000;
    logic therm = 1'b0;
    logic [2:0] pin_pd;
    logic [3:0] mask;
    logic sda_line;

    int checks = 0, fails = 0;
    logic [6:0] m_norm = 7'h7F, m_susp = 7'h7F;

    always #10 clk = ~clk;
    assign sda_line = m_sda & ~sda_pd;

    smb_pin_expander u_smb_pin_expander (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pd_o(sda_pd),
        .addr_sel_i(addr_sel), .suspend_n_i(suspend_n), .pin_i(pins),
        .therm_flag_i(therm), .pin_pd_o(pin_pd), .mask_o(mask)
    );

    function automatic logic [6:0] routed(input logic sn, input logic [6:0] n, input logic [6:0] s);
        return sn ? n : s;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start;
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
    endtask

    task automatic b_stop;
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic b_send(input logic b);
        m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(H);
    endtask

    task automatic b_recv(output logic b);
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2); b = sda_line; wt(H/2); m_scl = 1'b0; wt(H);
    endtask

    task automatic b_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) b_send(v[i]);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] v,
                            output logic ack1, output logic ack2);
        b_start(); b_byte({a, 1'b0}); b_recv(ack1);
        ack2 = 1'b1;
        if (!ack1) begin b_byte(v); b_recv(ack2); end
        b_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [2:0] pins_after,
                           output logic ack, output logic [7:0] v);
        logic b;
        b_start(); b_byte({a, 1'b1}); b_recv(ack);
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            b_recv(b);
            v[i] = b;
            if (i == 7) pins = pins_after;
        end
        b_send(1'b1);
        b_stop();
    endtask

    task automatic model_write(input logic [7:0] v);
        if (v[7]) m_norm = v[6:0]; else m_susp = v[6:0];
    endtask

    task automatic chk_outs(input string req);
        logic [6:0] r;
        r = routed(suspend_n, m_norm, m_susp);
        chk(req, {13'b0, pin_pd}, {13'b0, ~r[2:0]});
        chk(req, {12'b0, mask}, {12'b0, r[6:3]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic a1, a2, b;
        logic [7:0] v, rd;
        void'($urandom(32'd1661));
        wt(5); rst_n = 1'b1; wt(2);
        addr_sel = 2'b10;   // R1: moving the select after reset must not matter

        // R6 reset state in both routings
        chk("R6 reset pins", {13'b0, pin_pd}, 16'h0);
        chk("R6 reset mask", {12'b0, mask}, 16'hF);
        chk("R10 sda idle", {15'b0, sda_pd}, 16'h0);
        suspend_n = 1'b0; #2;
        chk("R6 reset susp mask", {12'b0, mask}, 16'hF);
        wt(1); suspend_n = 1'b1; wt(1);

        // R2 R3 R5 normal write
        do_write(OWN, 8'b1_0000_010, a1, a2); model_write(8'b1_0000_010);
        chk("R2 addr ack", {15'b0, a1}, 16'h0);
        chk("R2 data ack", {15'b0, a2}, 16'h0);
        chk_outs("R5 normal fields");
        // R7 combinational switch
        suspend_n = 1'b0; #2;
        chk_outs("R7 suspend routed");
        wt(1);
        do_write(OWN, 8'b0_1010_001, a1, a2); model_write(8'b0_1010_001);
        chk_outs("R3 suspend write");
        suspend_n = 1'b1; #2;
        chk_outs("R3 normal untouched");
        wt(1);

        // R1 old address still acknowledged; R9 other address ignored
        do_write(7'h48, 8'b1_0000_000, a1, a2);
        chk("R9 no ack", {15'b0, a1}, 16'h1);
        chk_outs("R9 no change");
        do_write(OWN, 8'b1_1111_100, a1, a2); model_write(8'b1_1111_100);
        chk("R1 address kept", {15'b0, a1}, 16'h0);
        chk_outs("R1 write landed");

        // R4 STOP after 4 data bits
        b_start(); b_byte({OWN, 1'b0}); b_recv(b);
        for (int i = 0; i < 4; i++) b_send(1'b0);
        b_stop();
        chk_outs("R4 stop abort");
        // R4 repeated START after 7 data bits, then full transfer
        b_start(); b_byte({OWN, 1'b0}); b_recv(b);
        for (int i = 0; i < 7; i++) b_send(1'b0);
        b_start(); b_byte({OWN, 1'b0}); b_recv(a1); b_byte(8'b1_0101_011); b_recv(a2); b_stop();
        model_write(8'b1_0101_011);
        chk_outs("R4 restart then write");

        // R8 read format, sample point; R10 release after NACK
        pins = 3'b101; therm = 1'b1;
        do_read(OWN, 3'b010, a1, rd);
        chk("R8 read ack", {15'b0, a1}, 16'h0);
        chk("R8 read byte", {8'b0, rd}, 16'h000D);
        chk("R10 released", {15'b0, sda_pd}, 16'h0);
        do_read(7'h20, 3'b010, a1, rd);
        chk("R9 read no ack", {15'b0, a1}, 16'h1);

        // random mix
        for (int k = 0; k < 24; k++) begin
            v = 8'($urandom);
            do_write(OWN, v, a1, a2); model_write(v);
            chk("R3 rnd ack", {14'b0, a1, a2}, 16'h0);
            suspend_n = 1'($urandom); #2;
            chk_outs("R7 rnd route");
            wt(1);
            pins = 3'($urandom); therm = 1'($urandom);
            v = {4'b0, therm, pins};
            do_read(OWN, 3'($urandom), a1, rd);
            chk("R8 rnd read", {8'b0, rd}, {8'b0, v});
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule